// File: doc/BRIEF.md
# Keyed Reset and Priority Control Register

This block is a single control register for an interrupt and reset subsystem. Software may change it only if the upper half of the write word holds a 16-bit unlock key. A write that carries the key can do three things. It can load a 3-bit priority-group value, which tells the interrupt logic where group priority ends and subpriority begins. It can raise a system reset request. It can ask for the active exception state to be cleared.

The reset request is a sticky output. It stays high until the external reset controller reports back that the reset is done, or until the block itself is reset. The clear-active request produces a single-cycle pulse, and only while the core reports that it is halted. A read port always shows the current register image. That image carries a fixed return key, a constant endianness flag chosen by a parameter, and the priority-group value.

Top module: `keyed_rst_ctrl`

## Requirements
- R1: A write takes effect only when `wr_data[31:16]` equals 0x05FA. With any other key value (0xFA05 included), the priority group, the reset request and the clear pulse stay exactly as they would be with no write.
- R2: A keyed write loads `wr_data[10:8]` into the priority group. The new value appears on `prio_group` and in `rd_data[10:8]` in the cycle after the write.
- R3: A keyed write with `wr_data[2]` = 1 raises `sys_rst_req` in the next cycle. It stays high while `rst_done` is low, and it drops in the cycle after `rst_done` is sampled high.
- R4: If a keyed write with `wr_data[2]` = 1 and a high `rst_done` are sampled in the same cycle, the set wins and `sys_rst_req` is high in the next cycle.
- R5: A keyed write with `wr_data[1]` = 1 while `core_halted` is high makes `clr_active_pulse` high for exactly the next cycle.
- R6: A keyed write with `wr_data[1]` = 1 while `core_halted` is low produces no clear pulse.
- R7: `rd_data[31:16]` always reads 0xFA05, and `rd_data[14:11]` and `rd_data[7:0]` always read 0. This includes the reset-request bit 2 and the clear bit 1.
- R8: `rd_data[15]` always equals the `BIG_ENDIAN` parameter (0 = little-endian, 1 = big-endian). Writes to bit 15 have no effect on it.
- R9: When `rst_n` is sampled low at a clock edge, the block clears `sys_rst_req`, `clr_active_pulse` and `prio_group` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data, key in bits 31:16 |
| core_halted | input | 1 | High while the core is halted |
| rst_done | input | 1 | Reset controller acknowledges the request |
| sys_rst_req | output | 1 | Sticky system reset request |
| clr_active_pulse | output | 1 | One-cycle request to clear active exception state |
| prio_group | output | 3 | Priority-group split value |
| rd_data | output | 32 | Current register image |

## Verification
Two functions can land in the same cycle: a keyed write that sets the reset request, and the reset controller's done acknowledgement that clears it. The bench provokes this by holding `rst_done` high during a keyed write with bit 2 set, with a request already pending. It then expects the request to stay high. Only after a later cycle in which `rst_done` is high and no set arrives does it expect the request to fall. A second overlap is also exercised: a keyed write that carries the clear bit together with a new group value. The bench judges it by checking that the pulse and the new group value appear in the same following cycle.

// File: rtl/krc_pkg.sv
// Package: shared widths, bit positions, key constants and the decoded
// write command used by the keyed reset/priority register.
// Assumes a 32-bit register word with the key in the upper half.
package krc_pkg;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int KEY_LSB    = DATA_W - KEY_W;
    localparam int GRP_W      = 3;
    localparam int GRP_LSB    = 8;
    localparam int GRP_MSB    = GRP_LSB + GRP_W - 1;
    localparam int ENDIAN_POS = 15;
    localparam int RST_POS    = 2;
    localparam int CLR_POS    = 1;

    localparam logic [KEY_W-1:0] WR_KEY = 16'h05FA;
    localparam logic [KEY_W-1:0] RD_KEY = 16'hFA05;

    // Decoded result of one write-port cycle
    typedef struct packed {
        logic             accept;
        logic [GRP_W-1:0] grp;
        logic             rst_set;
        logic             clr_req;
    } wr_cmd_t;
endpackage

// File: rtl/krc_key_gate.sv
// Key gate: compares the write key and splits an accepted write into
// its field actions. Purely combinational; a write without the key
// yields a command with every action low.
module krc_key_gate
    import krc_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    logic key_ok;
    logic wdata_unused;

    // Key compare on the upper half of the write word
    assign key_ok = (wr_data[DATA_W-1:KEY_LSB] == WR_KEY);

    // Bits with no write action are collected here on purpose
    assign wdata_unused = ^{wr_data[KEY_LSB-1:GRP_MSB+1],
                            wr_data[GRP_LSB-1:RST_POS+1],
                            wr_data[CLR_POS-1:0]};

    // Field split, gated by the accept condition
    always_comb begin
        cmd.accept  = wr_en && key_ok;
        cmd.grp     = wr_data[GRP_MSB:GRP_LSB];
        cmd.rst_set = cmd.accept && wr_data[RST_POS];
        cmd.clr_req = cmd.accept && wr_data[CLR_POS];
    end
endmodule

// File: rtl/krc_rst_latch.sv
// Reset request latch: set by an accepted write with the request bit,
// held until the reset controller acknowledges. A set in the same cycle
// as the acknowledge wins. Assumes rst_done is synchronous to clk.
module krc_rst_latch
    import krc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_cmd_t cmd,
    input  logic    rst_done,
    output logic    req
);
    // Sticky request with set priority over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)            req <= 1'b0;
        else if (cmd.rst_set)  req <= 1'b1;
        else if (rst_done)     req <= 1'b0;
    end

    // R3
    req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(cmd.accept && cmd.rst_set));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rst_done) |=> req);
    // R4
    req_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.rst_set && rst_done) |=> req);
endmodule

// File: rtl/krc_clr_pulse.sv
// Clear-active pulse: one cycle high after an accepted write with the
// clear bit while the core is halted. Assumes core_halted is synchronous.
module krc_clr_pulse
    import krc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_cmd_t cmd,
    input  logic    core_halted,
    output logic    pulse
);
    // Registered single-cycle pulse, qualified by the halt status
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= cmd.clr_req && core_halted;
    end

    // R6
    clr_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(core_halted));
    // R5
    clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(cmd.accept));
endmodule

// File: rtl/keyed_rst_ctrl.sv
// Keyed reset and priority control register (top). Holds the priority
// group, drives the reset request and the clear-active pulse, and builds
// the read image. Assumes one write per cycle and a synchronous reset.
module keyed_rst_ctrl
    import krc_pkg::*;
#(
    parameter logic BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              core_halted,
    input  logic              rst_done,
    output logic              sys_rst_req,
    output logic              clr_active_pulse,
    output logic [GRP_W-1:0]  prio_group,
    output logic [DATA_W-1:0] rd_data
);
    wr_cmd_t cmd;

    krc_key_gate u_gate (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    krc_rst_latch u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .rst_done (rst_done),
        .req      (sys_rst_req)
    );

    krc_clr_pulse u_clr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .core_halted (core_halted),
        .pulse       (clr_active_pulse)
    );

    // Priority-group field, loaded only by an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)          prio_group <= '0;
        else if (cmd.accept) prio_group <= cmd.grp;
    end

    // Read image: return key, endianness constant, group, zeros elsewhere
    always_comb begin
        rd_data                          = '0;
        rd_data[DATA_W-1:KEY_LSB]        = RD_KEY;
        rd_data[ENDIAN_POS]              = BIG_ENDIAN;
        rd_data[GRP_MSB:GRP_LSB]         = prio_group;
    end

    // R1
    grp_keyed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[DATA_W-1:KEY_LSB] == WR_KEY) |=> $stable(prio_group));
    // R2
    grp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.accept |=> (prio_group == $past(wr_data[GRP_MSB:GRP_LSB])));
endmodule

// File: tb/tb_keyed_rst_ctrl.sv
module tb_keyed_rst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, wr_en, core_halted, rst_done;
    logic [31:0] wr_data, rd_data;
    logic        sys_rst_req, clr_active_pulse;
    logic [2:0]  prio_group;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_rst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .core_halted(core_halted), .rst_done(rst_done),
        .sys_rst_req(sys_rst_req), .clr_active_pulse(clr_active_pulse),
        .prio_group(prio_group), .rd_data(rd_data)
    );

    // {wr_en, wr_data, halted, done, exp_req, exp_pulse, exp_grp}
    localparam int NV = 13;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 32'h05FA_0500, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5},
        {1'b1, 32'h1234_0700, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5},
        {1'b1, 32'h05FA_0304, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3},
        {1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3},
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3},
        {1'b1, 32'h05FA_0602, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6},
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6},
        {1'b1, 32'h05FA_0302, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
        {1'b1, 32'h05FA_0004, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {1'b1, 32'h05FA_0004, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0},
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {1'b1, 32'hFA05_0706, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {1'b1, 32'h05FA_8100, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R2 load group";
            1: return "R1 bad key";
            2: return "R3 request set";
            3: return "R3 request hold";
            4: return "R3 request clear";
            5: return "R5 clear pulse";
            6: return "R5 pulse single";
            7: return "R6 no pulse unhalted";
            8: return "R3 set again";
            9: return "R4 set beats done";
            10: return "R3 clear after overlap";
            11: return "R1 swapped key";
            default: return "R8 endian write";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R7 / R8: fixed parts of the read image
    task automatic chk_image(string tag, logic [2:0] grp);
        chk({tag, " R7 key"}, {16'h0, rd_data[31:16]}, 32'h0000_FA05);
        chk({tag, " R8 endian"}, {31'h0, rd_data[15]}, 32'h0);
        chk({tag, " R7 zeros"}, {19'h0, rd_data[14:11], rd_data[7:0]}, 32'h0);
        chk({tag, " R2 read group"}, {29'h0, rd_data[10:8]}, {29'h0, grp});
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; core_halted = 1'b0; rst_done = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 req at reset", {31'h0, sys_rst_req}, 32'h0);
        chk("R9 pulse at reset", {31'h0, clr_active_pulse}, 32'h0);
        chk("R9 group at reset", {29'h0, prio_group}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {wr_en, wr_data, core_halted, rst_done} = VEC[i][39:5];
            @(negedge clk);
            wr_en = 1'b0; rst_done = 1'b0;
            chk({vtag(i), " req"}, {31'h0, sys_rst_req}, {31'h0, VEC[i][4]});
            chk({vtag(i), " pulse"}, {31'h0, clr_active_pulse}, {31'h0, VEC[i][3]});
            chk({vtag(i), " group"}, {29'h0, prio_group}, {29'h0, VEC[i][2:0]});
            chk_image(vtag(i), VEC[i][2:0]);
        end
        // R5 / R2: clear and group load together, then pulse drops
        wr_en = 1'b1; wr_data = 32'h05FA_0702; core_halted = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 pulse with load", {31'h0, clr_active_pulse}, 32'h1);
        chk("R2 group with pulse", {29'h0, prio_group}, 32'h7);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'h0, clr_active_pulse}, 32'h0);
        // R9: reset clears a pending request and the group
        wr_en = 1'b1; wr_data = 32'h05FA_0504;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 request before reset", {31'h0, sys_rst_req}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 req cleared", {31'h0, sys_rst_req}, 32'h0);
        chk("R9 group cleared", {29'h0, prio_group}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 req stays low", {31'h0, sys_rst_req}, 32'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule